// File: doc/BRIEF.md
# Strap-Addressed Two-Wire Serial Slave

This block is the serial front end of a module management register file. It watches a two-wire bus (a clock line and an open-drain data line) and recognises start and stop conditions. It answers a 7-bit device address. The upper four bits of that address are fixed at binary 0101. The lower three bits come from board strap pins. Once it matches the address, it runs byte-wide reads and writes against an internal register port, using a pointer that advances after every data byte.

Both bus lines pass through a synchronizer. Edges are then found in the system clock domain. The block only ever pulls the data line low, through an output enable, and otherwise leaves it released. A host can recover a confused bus interface in one of two ways:
- Clock the bus nine times with data held high, then issue a start condition.
- Assert the active-low hard reset pin. While that pin is low, all bus traffic is ignored.

Top module: `strap_tws_slave`

## Requirements
- R1: After system reset, `sda_oe`, `reg_wr` and `reg_rd` are all low.
- R2: The address byte is acknowledged only when bits 7..4 equal 0101, bits 3..1 equal `addr_pins[2:0]` (pin 2 in bit 3), and bit 0 selects the direction (0 write, 1 read). Any other address is not acknowledged, and the rest of the transaction is ignored.
- R3: The byte B0h is never acknowledged, whatever the pin states.
- R4: In a write transaction, the first data byte loads the register pointer. Each later byte is acknowledged and presented on `reg_wr` at the current pointer, and the pointer then advances by one.
- R5: In a read transaction, the byte at the pointer is fetched with a one-cycle `reg_rd` and sent MSB first. The pointer advances after each byte and is kept across a repeated start, so a later read continues from there. `reg_wr` and `reg_rd` are never high together.
- R6: When the master answers a read byte with a NACK, the burst ends: no further fetch takes place and the data line stays released until the next start.
- R7: A start condition always begins a new address phase. After a stop, bytes clocked without a new start are not acknowledged.
- R8: Nine rising clock edges with data high, followed by a start, return the interface to idle and clear the pointer to zero. The address byte that follows that start is not acknowledged.
- R9: While `hard_rst_n` is low, `sda_oe` stays low and no register access occurs. Leaving hard reset finds the pointer at zero.
- R10: The block changes its drive of the data line only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| hard_rst_n | input | 1 | Active-low hard reset pin for the serial logic |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_pins | input | 3 | Strap pins giving device address bits 3..1 |
| sda_oe | output | 1 | High pulls the data line low; low releases it |
| reg_addr | output | 8 | Register pointer presented to the register file |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd | output | 1 | One-cycle fetch strobe |
| reg_rdata | input | 8 | Read data at `reg_addr`, valid in the same cycle |

## Verification
The assertions check the following on every cycle:
- A start enters the address phase and a stop idles the engine.
- A recovery start clears the state and the pointer.
- The write and fetch strobes never overlap.
- A write advances the pointer.
- The data drive only moves while the clock line is low.
- Hard reset keeps the line released.

Only the bench scenarios can show the rest:
- Address matching against the strap pins and the rejection of B0h.
- Pointer loading and its persistence across a repeated start.
- The data returned MSB first.
- The end of a burst after a NACK.
- The effect of recovery and of hard reset on a later read.

// File: rtl/twsl_pkg.sv
package twsl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK
  } tws_state_e;

  // 7-bit device address with the strap field set to zero
  localparam logic [6:0] DEV_BASE = 7'b0101000;

endpackage

// File: rtl/twsl_sampler.sv
module twsl_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start,
  output logic stop
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] lvl;
  logic [NLINES-1:0] prv;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;
    logic              prev_q;

    always_comb begin
      sh_d = {sh_q[STAGES-2:0], raw[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q   <= '1;
        prev_q <= 1'b1;
      end else begin
        sh_q   <= sh_d;
        prev_q <= sh_q[STAGES-1];
      end
    end

    assign lvl[g] = sh_q[STAGES-1];
    assign prv[g] = prev_q;
  end

  assign scl_lvl  = lvl[0];
  assign sda_lvl  = lvl[1];
  assign scl_rise = lvl[0] & ~prv[0];
  assign scl_fall = ~lvl[0] & prv[0];
  assign start    = lvl[0] & prv[0] & prv[1] & ~lvl[1];
  assign stop     = lvl[0] & prv[0] & ~prv[1] & lvl[1];

endmodule

// File: rtl/twsl_recover.sv
module twsl_recover #(
  parameter int CLOCKS = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  input  logic stop,
  input  logic scl_rise,
  input  logic sda_lvl,
  output logic recover
);

  localparam int CW = $clog2(CLOCKS + 1);
  localparam logic [CW-1:0] FULL = CW'(CLOCKS);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr || start || stop) begin
      cnt_d = '0;
    end else if (scl_rise) begin
      if (!sda_lvl)          cnt_d = '0;
      else if (cnt_q != FULL) cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign recover = start & ~clr & (cnt_q == FULL);

endmodule

// File: rtl/twsl_engine.sv
module twsl_engine
  import twsl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int PIN_BITS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                recover,
  input  logic                start,
  input  logic                stop,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                scl_lvl,
  input  logic                sda_lvl,
  input  logic [PIN_BITS-1:0] pins,
  output logic                sda_drive,
  output logic [ADDR_W-1:0]   reg_addr,
  output logic                reg_wr,
  output logic [7:0]          reg_wdata,
  output logic                reg_rd,
  input  logic [7:0]          reg_rdata
);

  localparam logic [3:0] LAST_BIT = 4'd8;

  tws_state_e        st_q, st_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [7:0]        sh_q, sh_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              drive_q, drive_d;
  logic              rw_q, rw_d;
  logic              first_q, first_d;
  logic              ack_q, ack_d;
  logic              fetch, wr;
  logic              addr_hit;

  assign addr_hit = (sh_q[7:PIN_BITS+1] == DEV_BASE[6:PIN_BITS]) &&
                    (sh_q[PIN_BITS:1] == pins);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    drive_d = drive_q;
    rw_d    = rw_q;
    first_d = first_q;
    ack_d   = ack_q;
    fetch   = 1'b0;
    wr      = 1'b0;
    if (clr || recover) begin
      st_d    = ST_IDLE;
      cnt_d   = '0;
      ptr_d   = '0;
      drive_d = 1'b0;
      first_d = 1'b1;
    end else if (start) begin
      st_d    = ST_ADDR;
      cnt_d   = '0;
      drive_d = 1'b0;
      first_d = 1'b1;
    end else if (stop) begin
      st_d    = ST_IDLE;
      drive_d = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR, ST_WDAT: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_lvl};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == LAST_BIT) begin
            if (st_q == ST_ADDR) begin
              if (addr_hit) begin
                st_d    = ST_AACK;
                drive_d = 1'b1;
                rw_d    = sh_q[0];
              end else begin
                st_d = ST_IDLE;
              end
            end else begin
              st_d    = ST_WACK;
              drive_d = 1'b1;
              if (first_q) begin
                ptr_d   = ADDR_W'(sh_q);
                first_d = 1'b0;
              end else begin
                wr    = 1'b1;
                ptr_d = ptr_q + ADDR_W'(1);
              end
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              fetch = 1'b1;
            end else begin
              st_d    = ST_WDAT;
              drive_d = 1'b0;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            st_d    = ST_WDAT;
            drive_d = 1'b0;
            cnt_d   = '0;
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              st_d    = ST_RACK;
              drive_d = 1'b0;
              ptr_d   = ptr_q + ADDR_W'(1);
            end else begin
              drive_d = ~sh_q[6];
              sh_d    = {sh_q[6:0], 1'b0};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            ack_d = ~sda_lvl;
          end else if (scl_fall) begin
            if (ack_q) fetch = 1'b1;
            else       st_d = ST_IDLE;
          end
        end
        default: ;
      endcase
      if (fetch) begin
        st_d    = ST_RDAT;
        sh_d    = reg_rdata;
        drive_d = ~reg_rdata[7];
        cnt_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      drive_q <= 1'b0;
      rw_q    <= 1'b0;
      first_q <= 1'b1;
      ack_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      drive_q <= drive_d;
      rw_q    <= rw_d;
      first_q <= first_d;
      ack_q   <= ack_d;
    end
  end

  assign sda_drive = drive_q;
  assign reg_addr  = ptr_q;
  assign reg_wr    = wr;
  assign reg_wdata = sh_q;
  assign reg_rd    = fetch;

  // R7: a plain start opens the address phase
  assert_start_addr_R7: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (start && !recover) |=> (st_q == ST_ADDR));

  // R7: a stop returns the engine to idle
  assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n || clr)
    stop |=> (st_q == ST_IDLE));

  // R8: recovery clears state and pointer
  assert_recover_clear_R8: assert property (@(posedge clk) disable iff (!rst_n || clr)
    recover |=> (st_q == ST_IDLE && ptr_q == '0));

  // R5: write and fetch strobes never overlap
  assert_rw_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  // R4: each register write advances the pointer
  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n || clr)
    reg_wr |=> (reg_addr == $past(reg_addr) + ADDR_W'(1)));

  // R10: the data drive only moves while the clock line is low
  assert_sda_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (drive_q != $past(drive_q)) |-> !scl_lvl);

endmodule

// File: rtl/strap_tws_slave.sv
module strap_tws_slave #(
  parameter int ADDR_W         = 8,
  parameter int PIN_BITS       = 3,
  parameter int SYNC_STAGES    = 2,
  parameter int RECOVER_CLOCKS = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hard_rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic [PIN_BITS-1:0] addr_pins,
  output logic                sda_oe,
  output logic [ADDR_W-1:0]   reg_addr,
  output logic                reg_wr,
  output logic [7:0]          reg_wdata,
  output logic                reg_rd,
  input  logic [7:0]          reg_rdata
);

  logic [SYNC_STAGES-1:0] hard_sh_q;
  logic                   hard_ok;
  logic                   clr;
  logic                   scl_lvl, sda_lvl, scl_rise, scl_fall, start, stop;
  logic                   recover;
  logic                   sda_drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hard_sh_q <= '0;
    else        hard_sh_q <= {hard_sh_q[SYNC_STAGES-2:0], hard_rst_n};
  end

  assign hard_ok = hard_sh_q[SYNC_STAGES-1];
  assign clr     = ~hard_ok;

  twsl_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start    (start),
    .stop     (stop)
  );

  twsl_recover #(.CLOCKS(RECOVER_CLOCKS)) u_recover (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .start    (start),
    .stop     (stop),
    .scl_rise (scl_rise),
    .sda_lvl  (sda_lvl),
    .recover  (recover)
  );

  twsl_engine #(.ADDR_W(ADDR_W), .PIN_BITS(PIN_BITS)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .recover   (recover),
    .start     (start),
    .stop      (stop),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .pins      (addr_pins),
    .sda_drive (sda_drive),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata)
  );

  // The raw pin gates the pull-down so release does not wait for the synchronizer
  assign sda_oe = sda_drive & hard_rst_n;

  // R9: a synchronized hard reset always leaves the line released
  assert_hard_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hard_ok |-> !sda_oe);

endmodule

// File: tb/strap_tws_slave_test.sv
module strap_tws_slave_test;

  localparam int CLK_P = 10;
  localparam int Q     = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       hard_rst_n;
  logic       scl_m, sda_m;
  logic [2:0] addr_pins;
  logic       sda_oe;
  logic [7:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic       reg_rd;
  logic [7:0] reg_rdata;
  logic       sda_line;

  int tests = 0;
  int fails = 0;
  int rd_cnt = 0;
  int edge_viol = 0;
  int hard_pull = 0;
  logic in_hard = 1'b0;
  logic done = 1'b0;
  logic oe_prev = 1'b0;
  string cur_req = "R1";

  logic [7:0]  mem [0:255];
  logic [15:0] exp_q [$];

  always #(CLK_P/2) clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  strap_tws_slave uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .hard_rst_n (hard_rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .addr_pins  (addr_pins),
    .sda_oe     (sda_oe),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata)
  );

  function automatic logic [7:0] init_val(input logic [7:0] a);
    return a ^ 8'hA5;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // register model and scoreboard monitor
  always @(posedge clk) if (reg_wr) mem[reg_addr] <= reg_wdata;

  always @(negedge clk) begin
    if (rst_n && reg_wr) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s: actual write %0h@%0h expected none", cur_req, reg_wdata, reg_addr);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        if ({reg_addr, reg_wdata} !== e) begin
          fails++;
          $display("FAIL R4: actual %0h expected %0h", {reg_addr, reg_wdata}, e);
        end
      end
    end
    if (rst_n && reg_rd) rd_cnt++;
    if (rst_n && (sda_oe !== oe_prev) && scl_m) edge_viol++;
    if (in_hard && sda_oe) hard_pull++;
    oe_prev <= sda_oe;
  end

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic clock_bit(input logic b, output logic r);
    sda_m = b;    wait_q();
    scl_m = 1'b1; wait_q();
    r = sda_line; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clock_bit(d[i], r);
    clock_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    logic r;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b1, r);
      d = {d[6:0], r};
    end
    clock_bit(nack, r);
  endtask

  task automatic push_wr(input logic [7:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] d;
    logic [8:0] tail;
    logic       r;
    int         rd_before;
    for (int i = 0; i < 256; i++) mem[i] = init_val(8'(i));
    rst_n = 1'b0; hard_rst_n = 1'b1; scl_m = 1'b1; sda_m = 1'b1; addr_pins = 3'b101;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1", {sda_oe, reg_wr, reg_rd}, 3'b000);

    // R4 write burst: 5Ah, pointer 10h, three data bytes
    cur_req = "R4";
    bus_start();
    send_byte(8'h5A, ack); chk("R2", ack, 1'b1);
    send_byte(8'h10, ack); chk("R4", ack, 1'b1);
    push_wr(8'h10, 8'h3C); send_byte(8'h3C, ack); chk("R4", ack, 1'b1);
    push_wr(8'h11, 8'hC3); send_byte(8'hC3, ack); chk("R4", ack, 1'b1);
    push_wr(8'h12, 8'h7E); send_byte(8'h7E, ack); chk("R4", ack, 1'b1);
    bus_stop();
    chk("R4", exp_q.size(), 0);

    // R5 random read: pointer 11h then repeated start and read
    cur_req = "R5";
    bus_start();
    send_byte(8'h5A, ack); chk("R2", ack, 1'b1);
    send_byte(8'h11, ack); chk("R4", ack, 1'b1);
    bus_start();
    send_byte(8'h5B, ack); chk("R5", ack, 1'b1);
    recv_byte(1'b0, d); chk("R5", d, 8'hC3);
    recv_byte(1'b0, d); chk("R5", d, 8'h7E);
    recv_byte(1'b1, d); chk("R5", d, init_val(8'h13));
    bus_stop();
    bus_start();
    send_byte(8'h5B, ack); chk("R5", ack, 1'b1);
    recv_byte(1'b1, d); chk("R5", d, init_val(8'h14));
    // R6: after the NACK the slave stays released and fetches nothing
    cur_req = "R6";
    rd_before = rd_cnt;
    for (int i = 0; i < 9; i++) begin
      clock_bit(1'b1, r);
      tail = {tail[7:0], r};
    end
    chk("R6", tail, 9'h1FF);
    chk("R6", rd_cnt, rd_before);
    bus_stop();

    // R2 mismatched strap value gets no acknowledge and no write
    cur_req = "R2";
    bus_start();
    send_byte(8'h58, ack); chk("R2", ack, 1'b0);
    send_byte(8'h00, ack); chk("R2", ack, 1'b0);
    bus_stop();
    addr_pins = 3'b000;
    bus_start();
    send_byte(8'h50, ack); chk("R2", ack, 1'b1);
    send_byte(8'h40, ack);
    push_wr(8'h40, 8'h99); send_byte(8'h99, ack); chk("R2", ack, 1'b1);
    bus_stop();

    // R3 B0h never acknowledged
    cur_req = "R3";
    bus_start();
    send_byte(8'hB0, ack); chk("R3", ack, 1'b0);
    send_byte(8'h33, ack); chk("R3", ack, 1'b0);
    bus_stop();
    addr_pins = 3'b101;

    // R7 bytes after a stop without a start are ignored
    cur_req = "R7";
    scl_m = 1'b0; wait_q();
    send_byte(8'h5A, ack); chk("R7", ack, 1'b0);
    bus_stop();

    // R8 recovery: pointer 30h, then nine high clocks and a start
    cur_req = "R8";
    bus_start();
    send_byte(8'h5A, ack);
    send_byte(8'h30, ack); chk("R8", ack, 1'b1);
    bus_stop();
    scl_m = 1'b0; wait_q();
    for (int i = 0; i < 9; i++) clock_bit(1'b1, r);
    bus_start();
    send_byte(8'h5B, ack); chk("R8", ack, 1'b0);
    bus_stop();
    bus_start();
    send_byte(8'h5B, ack); chk("R8", ack, 1'b1);
    recv_byte(1'b1, d); chk("R8", d, init_val(8'h00));
    bus_stop();

    // R9 hard reset: no acknowledge, no write, line released, pointer cleared
    cur_req = "R9";
    hard_rst_n = 1'b0;
    in_hard = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9", sda_oe, 1'b0);
    bus_start();
    send_byte(8'h5A, ack); chk("R9", ack, 1'b0);
    send_byte(8'h20, ack);
    send_byte(8'h11, ack);
    bus_stop();
    chk("R9", hard_pull, 0);
    in_hard = 1'b0;
    hard_rst_n = 1'b1;
    repeat (6) @(negedge clk);
    bus_start();
    send_byte(8'h5B, ack); chk("R9", ack, 1'b1);
    recv_byte(1'b1, d); chk("R9", d, init_val(8'h00));
    bus_stop();

    // R10 drive changes only with the clock line low
    chk("R10", edge_viol, 0);
    chk("R4", exp_q.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule